// File: doc/BRIEF.md
# SPI Master with Selectable Clock Mode, Word Length and Bit Order

This block is the controller side of a serial peripheral link that has one peripheral on it. The host sets four static controls: the idle level of the serial clock, the edge on which data is captured, a short-word flag that picks 7-bit words over 8-bit words, and the bit order. It then pulses a start request together with a transmit word. The block pulls the active-low select line low and produces the serial clock from the system clock through a programmable half-period divider. It shifts the transmit word out while it shifts a word of the same length in from the peripheral.

When the last capture edge has passed, the block pulses a one-cycle completion strobe and presents the received word. It then finishes the clock so that the line rests at its idle level, waits one more half-period, and releases the select line. A transfer that only reads starts in the same way, with a don't-care transmit word.

Top module: `spi_mode_master`

## Requirements
- R1: After reset, and whenever no transfer runs, `ssN` is 1, `busy` is 0, `doneStrobe` is 0, and `sclk` equals `cpol` as sampled one clock earlier. Reset leaves `sclk` at 0.
- R2: A `startReq` high while the block is idle is accepted on that clock edge. From the next cycle, `ssN` is 0 and `busy` is 1. A `startReq` during a transfer is ignored: the running transfer keeps its data and produces exactly one completion strobe.
- R3: The serial clock toggles every H system clocks, where H is `halfDiv`, and a `halfDiv` of 0 counts as 1. A transfer of N bits makes exactly 2N toggles and ends with `sclk` at its idle level.
- R4: With `cpha`=0, both sides capture on the first (leading) edge of each bit period and change data on the second (trailing) edge. The first transmit bit is on `mosi` in the first cycle that `ssN` is low, before any clock edge.
- R5: With `cpha`=1, data changes on the leading edge of each bit period and is captured on the trailing edge.
- R6: With `shortWord`=1, N is 7. Only `txWord[6:0]` is sent, the received bits land in `rxWord[6:0]`, and `rxWord[7]` is 0. With `shortWord`=0, N is 8 and all bits are used.
- R7: With `lsbFirst`=1, bit 0 goes out and comes in first. With `lsbFirst`=0, bit N-1 is first. Received bits are stored at the same positions as the bits sent.
- R8: `doneStrobe` is high for exactly one cycle, the cycle right after the last capture edge, and `rxWord` holds the received word from then until the next start. Counted from the accepting edge, the strobe is high (2N-1)·H cycles later for `cpha`=0 and 2N·H cycles later for `cpha`=1.
- R9: `ssN` returns to 1 one half-period after the final clock edge, (2N+1)·H cycles after the accepting edge. A new start is accepted from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: capture on leading edge; 1: capture on trailing edge |
| shortWord | input | 1 | 1 selects 7-bit words, 0 selects 8-bit words |
| lsbFirst | input | 1 | 1 sends the least significant bit first |
| halfDiv | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| startReq | input | 1 | Start a transfer when idle |
| txWord | input | WORD_W | Word to transmit, sampled with the start |
| busy | output | 1 | Transfer in progress |
| rxWord | output | WORD_W | Received word |
| doneStrobe | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| ssN | output | 1 | Active-low peripheral select |

## Verification
Every check is timed from the clock edge that accepts the start. The select line falls one cycle after that edge. The completion strobe is due (2N-1)·H cycles later when capturing on the leading edge and 2N·H cycles later when capturing on the trailing edge, and the select line rises (2N+1)·H cycles after the accepting edge. The bench keeps a free-running cycle count and records it at the first falling clock edge after acceptance. It samples every output on falling clock edges, so the differences it compares against those formulas are exact cycle counts. A behavioural peripheral model follows the requirement rules for each mode, length and order, so that the received word and the word the peripheral captured can both be checked against scoreboard entries.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // accept a new word and reset bit pointers
    logic shift;   // present the next transmit bit
    logic sample;  // capture the receive bit
  } spimStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } spimState_t;

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             shortWord,
  input  logic [DIV_W-1:0] halfDiv,
  output spimStrobe_t      strb,
  output logic             sclk,
  output logic             ssN,
  output logic             busy,
  output logic             doneStrobe
);

  localparam int EDGE_W = $clog2(2*WORD_W+1);

  spimState_t        state;
  logic [DIV_W-1:0]  cnt, hEffQ, hEffIn;
  logic [EDGE_W-1:0] edgeIdx, lastEdgeQ, lastEdgeIn, lastSampleIdx;
  logic              cphaQ, sclkQ, ssNQ, doneQ;
  logic              edgeNow, leading, isSample, isShift;

  // Configuration decoded at start
  always_comb begin
    hEffIn     = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
    lastEdgeIn = shortWord ? EDGE_W'(2*WORD_W-3) : EDGE_W'(2*WORD_W-1);
  end

  // Edge classification: even edge index is the leading edge of a bit period
  always_comb begin
    edgeNow       = (state == ST_RUN) && (cnt == '0);
    leading       = ~edgeIdx[0];
    isSample      = edgeNow && (leading ^ cphaQ);
    isShift       = edgeNow && !(leading ^ cphaQ) &&
                    (cphaQ ? (edgeIdx != '0) : (edgeIdx != lastEdgeQ));
    lastSampleIdx = cphaQ ? lastEdgeQ : (lastEdgeQ - EDGE_W'(1));
    strb.load     = (state == ST_IDLE) && startReq;
    strb.shift    = isShift;
    strb.sample   = isSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hEffQ     <= DIV_W'(1);
      edgeIdx   <= '0;
      lastEdgeQ <= '0;
      cphaQ     <= 1'b0;
      sclkQ     <= 1'b0;
      ssNQ      <= 1'b1;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sclkQ <= cpol;
          if (startReq) begin
            state     <= ST_RUN;
            ssNQ      <= 1'b0;
            cphaQ     <= cpha;
            hEffQ     <= hEffIn;
            lastEdgeQ <= lastEdgeIn;
            cnt       <= hEffIn - DIV_W'(1);
            edgeIdx   <= '0;
          end
        end
        ST_RUN: begin
          if (cnt == '0) begin
            sclkQ   <= ~sclkQ;
            cnt     <= hEffQ - DIV_W'(1);
            edgeIdx <= edgeIdx + EDGE_W'(1);
            if (isSample && (edgeIdx == lastSampleIdx)) doneQ <= 1'b1;
            if (edgeIdx == lastEdgeQ) state <= ST_TAIL;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        ST_TAIL: begin
          if (cnt == '0) begin
            ssNQ  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk       = sclkQ;
  assign ssN        = ssNQ;
  assign busy       = (state != ST_IDLE);
  assign doneStrobe = doneQ;

endmodule

// File: rtl/spim_dpath.sv
module spim_dpath
  import spim_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strb,
  input  logic [WORD_W-1:0] txWord,
  input  logic              shortWord,
  input  logic              lsbFirst,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rxWord
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam int CNT_W = $clog2(WORD_W+1);

  logic [WORD_W-1:0] txQ, rxQ;
  logic [CNT_W-1:0]  outCnt, inCnt, lenQ, lenIn, nextOut;
  logic              lsbQ, mosiQ;

  // Position in the word of the i-th bit on the wire
  function automatic logic [IDX_W-1:0] bitPos(input logic [CNT_W-1:0] i,
                                               input logic             lsb,
                                               input logic [CNT_W-1:0] len);
    logic [CNT_W-1:0] p;
    p = lsb ? i : (len - CNT_W'(1) - i);
    return p[IDX_W-1:0];
  endfunction

  always_comb begin
    lenIn   = shortWord ? CNT_W'(WORD_W-1) : CNT_W'(WORD_W);
    nextOut = outCnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txQ    <= '0;
      rxQ    <= '0;
      outCnt <= '0;
      inCnt  <= '0;
      lenQ   <= CNT_W'(WORD_W);
      lsbQ   <= 1'b0;
      mosiQ  <= 1'b0;
    end else if (strb.load) begin
      txQ    <= txWord;
      rxQ    <= '0;
      outCnt <= '0;
      inCnt  <= '0;
      lenQ   <= lenIn;
      lsbQ   <= lsbFirst;
      mosiQ  <= txWord[bitPos('0, lsbFirst, lenIn)];
    end else begin
      if (strb.shift) begin
        outCnt <= nextOut;
        mosiQ  <= txQ[bitPos(nextOut, lsbQ, lenQ)];
      end
      if (strb.sample) begin
        rxQ[bitPos(inCnt, lsbQ, lenQ)] <= miso;
        inCnt <= inCnt + CNT_W'(1);
      end
    end
  end

  assign mosi   = mosiQ;
  assign rxWord = rxQ;

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
  import spim_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              shortWord,
  input  logic              lsbFirst,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic              startReq,
  input  logic [WORD_W-1:0] txWord,
  output logic              busy,
  output logic [WORD_W-1:0] rxWord,
  output logic              doneStrobe,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ssN
);

  spimStrobe_t strb;

  spim_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cpol       (cpol),
    .cpha       (cpha),
    .shortWord  (shortWord),
    .halfDiv    (halfDiv),
    .strb       (strb),
    .sclk       (sclk),
    .ssN        (ssN),
    .busy       (busy),
    .doneStrobe (doneStrobe)
  );

  spim_dpath #(.WORD_W(WORD_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txWord    (txWord),
    .shortWord (shortWord),
    .lsbFirst  (lsbFirst),
    .miso      (miso),
    .mosi      (mosi),
    .rxWord    (rxWord)
  );

endmodule

// File: rtl/spi_mode_master_chk.sv
module spi_mode_master_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic cpol,
  input logic busy,
  input logic ssN,
  input logic sclk,
  input logic doneStrobe
);

  // R1: idle clock level follows cpol, select released
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol && ssN));

  // R2: accepted start selects the peripheral next cycle
  assert_start_select_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && !ssN));

  // R8: completion strobe lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R8: completion strobe only inside a selected transfer
  assert_done_inside_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (busy && !ssN));

  // R9: select is released whenever the block is idle
  assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ssN);

endmodule

bind spi_mode_master spi_mode_master_chk chk_i (.*);

// File: tb/spi_mode_master_tb_top.sv
module spi_mode_master_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpol = 1'b0, cpha = 1'b0, shortWord = 1'b0, lsbFirst = 1'b0;
  logic [7:0] halfDiv = 8'd1;
  logic       startReq = 1'b0;
  logic [7:0] txWord = 8'h00;
  logic       busy, doneStrobe, sclk, mosi, ssN;
  logic [7:0] rxWord;
  logic       miso = 1'b0;

  spi_mode_master dut_i (
    .clk(clk), .rstN(rstN), .cpol(cpol), .cpha(cpha), .shortWord(shortWord),
    .lsbFirst(lsbFirst), .halfDiv(halfDiv), .startReq(startReq), .txWord(txWord),
    .busy(busy), .rxWord(rxWord), .doneStrobe(doneStrobe), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  always #5 clk = ~clk;

  int nTests = 0, nFail = 0, cyc = 0;
  int startCyc = 0, doneCnt = 0, toggles = 0;
  logic prevSclk = 1'b0;

  typedef struct { logic [7:0] rx; logic [7:0] capt; int lat; } exp_t;
  exp_t q[$];

  task automatic chk(string req, int act, int expv);
    nTests++;
    if (act != expv) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int lenTb();
    return shortWord ? 7 : 8;
  endfunction

  function automatic int posTb(int i);
    return lsbFirst ? i : lenTb() - 1 - i;
  endfunction

  // Cycle counter and watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // Peripheral model, written from R4..R7
  logic [7:0] slvPat = 8'h00, slvRx = 8'h00;
  int sIn = 0, sOut = 0;

  always @(negedge ssN) begin
    sIn = 0; sOut = 0; slvRx = 8'h00;
    if (!cpha) miso = slvPat[posTb(0)];
  end

  always @(sclk) begin
    if (rstN && ssN === 1'b0) begin
      if ((sclk != cpol) ^ cpha) begin
        slvRx[posTb(sIn)] = mosi;
        sIn++;
      end else if (cpha) begin
        miso = slvPat[posTb(sOut)];
        sOut++;
      end else begin
        sOut++;
        if (sOut < lenTb()) miso = slvPat[posTb(sOut)];
      end
    end
  end

  // Monitor: scoreboard pop on completion, toggle counting
  always @(negedge clk) begin
    if (rstN && ssN === 1'b0 && sclk !== prevSclk) toggles++;
    prevSclk = sclk;
    if (rstN && doneStrobe === 1'b1) begin
      doneCnt++;
      if (q.size() == 0) chk("R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk("R6/R7 rxWord", int'(rxWord), int'(e.rx));
        chk("R4/R5 peripheral captured", int'(slvRx), int'(e.capt));
        chk("R8 done latency", cyc - startCyc, e.lat);
      end
    end
  end

  // Driver
  task automatic xfer(input logic pol, input logic pha, input logic w7,
                      input logic lsb, input int h, input logic [7:0] tx,
                      input logic [7:0] pat, input bit retrigger);
    int n, hEff, togBase, doneBase;
    logic [7:0] mask;
    exp_t e;
    @(negedge clk);
    cpol = pol; cpha = pha; shortWord = w7; lsbFirst = lsb;
    halfDiv = 8'(h); slvPat = pat;
    @(negedge clk);
    n = w7 ? 7 : 8;
    hEff = (h == 0) ? 1 : h;
    mask = w7 ? 8'h7F : 8'hFF;
    e.rx = pat & mask; e.capt = tx & mask;
    e.lat = pha ? 2*n*hEff : (2*n-1)*hEff;
    q.push_back(e);
    togBase = toggles; doneBase = doneCnt;
    chk("R1 idle sclk level", int'(sclk), int'(pol));
    startReq = 1'b1; txWord = tx;
    @(negedge clk);
    startReq = 1'b0; startCyc = cyc;
    chk("R2 ssN low after start", int'(ssN), 0);
    chk("R2 busy after start", int'(busy), 1);
    if (!pha) chk("R4 first bit before clock", int'(mosi), int'(tx[lsb ? 0 : n-1]));
    if (retrigger) begin
      repeat (3) @(negedge clk);
      startReq = 1'b1; txWord = ~tx;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (busy) @(negedge clk);
    chk("R9 select release time", cyc - startCyc, (2*n+1)*hEff);
    chk("R9 ssN high at end", int'(ssN), 1);
    chk("R3 toggle count", toggles - togBase, 2*n);
    chk("R3 sclk back to idle", int'(sclk), int'(pol));
    chk("R2 exactly one done", doneCnt - doneBase, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ssN", int'(ssN), 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(doneStrobe), 0);
    chk("R1 reset sclk", int'(sclk), 0);
    rstN = 1'b1;
    @(negedge clk);
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle follows cpol", int'(sclk), 1);
    chk("R1 idle ssN", int'(ssN), 1);
    // R4 / R5 all four modes, 8-bit MSB-first
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 1, 8'hA5, 8'h3C, 1'b0);
    xfer(1'b0, 1'b1, 1'b0, 1'b0, 2, 8'h5A, 8'hC3, 1'b0);
    xfer(1'b1, 1'b0, 1'b0, 1'b0, 3, 8'h81, 8'h7E, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 1'b0, 1, 8'h96, 8'h01, 1'b0);
    // R7 LSB-first
    xfer(1'b0, 1'b0, 1'b0, 1'b1, 2, 8'h01, 8'h80, 1'b0);
    xfer(1'b1, 1'b1, 1'b0, 1'b1, 1, 8'hC4, 8'h2B, 1'b0);
    // R6 7-bit words, both orders
    xfer(1'b0, 1'b0, 1'b1, 1'b0, 1, 8'hC0, 8'hFF, 1'b0);
    xfer(1'b0, 1'b1, 1'b1, 1'b1, 2, 8'h41, 8'h55, 1'b0);
    xfer(1'b1, 1'b0, 1'b1, 1'b1, 1, 8'h7F, 8'h2A, 1'b0);
    // R3 zero divider acts as one
    xfer(1'b0, 1'b1, 1'b0, 1'b0, 0, 8'hE7, 8'h18, 1'b0);
    // R2 start during transfer ignored
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 2, 8'h3D, 8'hB2, 1'b1);
    // R9 back-to-back start right after release
    xfer(1'b1, 1'b0, 1'b0, 1'b1, 1, 8'h12, 8'hED, 1'b0);
    chk("R8 scoreboard drained", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule